// File: doc/BRIEF.md
# Frame Sync Hold and Loss Declaration

This block keeps frame alignment after an acquisition search has locked, and decides when alignment has been lost. A one-cycle pulse from the acquisition logic arms the block: a small confidence counter is loaded to its full value and the sync-held output goes high. Once per frame, on the word-28 strobe, the block looks at a set of count-of-eight flags. Each flag comes from a bit-error monitor and is high when that monitor has seen eight or more errors. If at least one monitor is still below eight errors, confidence rises. If every monitor has reached eight, confidence falls by one.

The counter saturates at its full value. When it reaches zero, sync-held drops at once, which lets the acquisition search run again. The loss-of-frame flag is raised on the first end-of-scan pulse after that point, and it stays up until the next acquisition pulse. The acquisition search itself is outside this block.

Top module: `fsync_hold_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, sync_held_o is 0, lof_o is 0 and conf_o is 0.
- R2: One clock edge after acq_found_i is high, conf_o is 5 and sync_held_o is 1, whatever the state before.
- R3: While sync is held, conf_o changes only on edges where word28_i is high (or acq_found_i is high).
- R4: A word-28 decision with at least one bit of err8_i at 0 counts up. Bit i of err8_i is 1 when monitor i has reached eight or more errors. The increment takes place only when conf_o is between 1 and 4. At 5 the value stays at 5.
- R5: A word-28 decision with every bit of err8_i at 1 lowers conf_o by one.
- R6: Five consecutive down decisions from 5 bring conf_o to 0. sync_held_o falls on the same edge on which conf_o reaches 0.
- R7: lof_o rises on the edge of the first eos_i pulse sampled strictly after the edge on which conf_o reached 0. It then stays high until an acquisition pulse. An eos_i pulse on the edge on which zero is reached does not set it.
- R8: While sync_held_o is 0, word28_i has no effect: conf_o stays 0 and lof_o changes only through eos_i or acq_found_i.
- R9: An acquisition pulse clears lof_o and cancels any pending loss, so a later eos_i pulse does not raise lof_o.
- R10: conf_o never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_found_i | input | 1 | Acquisition succeeded (one-cycle pulse) |
| err8_i | input | 3 | Per-monitor flag: eight or more errors seen |
| word28_i | input | 1 | Word-28 decision strobe |
| eos_i | input | 1 | End-of-scan pulse |
| sync_held_o | output | 1 | Frame sync held; low releases the acquisition search |
| lof_o | output | 1 | Loss of frame flag |
| conf_o | output | 3 | Confidence count |

## Verification
The assertions assume the following about the inputs:
- The err8_i flags are stable, known levels in each cycle where word28_i is high.
- acq_found_i is a clean pulse. If it is held high, the block keeps reloading and no decision is ever applied.

The stimulus is random with a fixed seed and keeps to these assumptions. acq_found_i is a rare single-cycle pulse. err8_i is biased toward all-ones, so the counter spends time near and at zero. eos_i is placed independently of the strobes, so it sometimes lands on the same edge as the fall to zero.

Directed sequences cover the following cases:
- five straight down decisions;
- saturation at 5;
- eos_i on the zero edge;
- an acquisition pulse while a loss is still pending.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  parameter int FS_NUM_MON   = 3;
  parameter int FS_CNT_MAX   = 5;
  parameter int FS_CNT_PRE   = 5;

  typedef enum logic [0:0] {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } vote_dir_e;
endpackage

// File: rtl/fs_vote.sv
module fs_vote
  import fsync_pkg::*;
#(
  parameter int NUM_MON = FS_NUM_MON
) (
  input  logic [NUM_MON-1:0] err8_i,
  output vote_dir_e          dir_o
);
  logic [NUM_MON:0] all_hi;

  assign all_hi[0] = 1'b1;
  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    assign all_hi[g+1] = all_hi[g] & err8_i[g];
  end

  assign dir_o = all_hi[NUM_MON] ? DIR_DOWN : DIR_UP;
endmodule

// File: rtl/fs_conf_cnt.sv
module fs_conf_cnt
  import fsync_pkg::*;
#(
  parameter int CNT_MAX = FS_CNT_MAX,
  parameter int CNT_PRE = FS_CNT_PRE,
  parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  vote_dir_e        dir_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             held_o,
  output logic             zero_hit_o
);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] PREV = CNT_W'(CNT_PRE);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             held_q, held_d;
  logic             hit_d;

  always_comb begin
    cnt_d  = cnt_q;
    held_d = held_q;
    hit_d  = 1'b0;
    if (load_i) begin
      cnt_d  = PREV;
      held_d = 1'b1;
    end else if (step_i && held_q) begin
      if (dir_i == DIR_UP) begin
        if ((cnt_q >= ONE) && (cnt_q < MAXV)) cnt_d = cnt_q + ONE;
      end else begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) begin
          held_d = 1'b0;
          hit_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign held_o     = held_q;
  assign zero_hit_o = hit_d;

  // R10
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAXV);
  // R2
  a_r2_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == PREV) && held_q);
  // R3
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(cnt_q) && $stable(held_q));
  // R5
  a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && step_i && held_q && dir_i == DIR_DOWN) |=> (cnt_q == $past(cnt_q) - ONE));
  // R8
  a_r8_dropped_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !held_q) |=> !held_q && (cnt_q == '0));
  // R6
  a_r6_held_tracks_zero: assert property (@(posedge clk) disable iff (!rst_n)
    held_q == (cnt_q != '0));
endmodule

// File: rtl/fs_lof_sync.sv
module fs_lof_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic zero_hit_i,
  input  logic eos_i,
  output logic lof_o
);
  logic pend_q, pend_d;
  logic lof_q, lof_d;

  always_comb begin
    pend_d = pend_q;
    lof_d  = lof_q;
    if (clr_i) begin
      pend_d = 1'b0;
      lof_d  = 1'b0;
    end else begin
      if (pend_q && eos_i) begin
        lof_d  = 1'b1;
        pend_d = 1'b0;
      end
      if (zero_hit_i) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lof_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      lof_q  <= lof_d;
    end
  end

  assign lof_o = lof_q;

  // R7
  a_r7_rise_on_eos: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof_q) |-> $past(eos_i) && $past(pend_q));
  // R7
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lof_q && !clr_i) |=> lof_q);
  // R9
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !lof_q && !pend_q);
endmodule

// File: rtl/fsync_hold_ctrl.sv
module fsync_hold_ctrl
  import fsync_pkg::*;
#(
  parameter int NUM_MON = FS_NUM_MON,
  parameter int CNT_MAX = FS_CNT_MAX,
  parameter int CNT_PRE = FS_CNT_PRE,
  localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acq_found_i,
  input  logic [NUM_MON-1:0] err8_i,
  input  logic               word28_i,
  input  logic               eos_i,
  output logic               sync_held_o,
  output logic               lof_o,
  output logic [CNT_W-1:0]   conf_o
);
  vote_dir_e dir;
  logic      zero_hit;

  fs_vote #(.NUM_MON(NUM_MON)) u_vote (
    .err8_i (err8_i),
    .dir_o  (dir)
  );

  fs_conf_cnt #(.CNT_MAX(CNT_MAX), .CNT_PRE(CNT_PRE), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (acq_found_i),
    .step_i     (word28_i),
    .dir_i      (dir),
    .cnt_o      (conf_o),
    .held_o     (sync_held_o),
    .zero_hit_o (zero_hit)
  );

  fs_lof_sync u_lof (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (acq_found_i),
    .zero_hit_i (zero_hit),
    .eos_i      (eos_i),
    .lof_o      (lof_o)
  );

  // R4
  a_r4_up_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_found_i && word28_i && sync_held_o && !(&err8_i) && conf_o == CNT_W'(CNT_MAX))
      |=> conf_o == CNT_W'(CNT_MAX));
  // R6
  a_r6_lof_needs_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof_o) |-> !sync_held_o);
endmodule

// File: tb/fsync_hold_ctrl_tb_top.sv
module fsync_hold_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acq, w28, eos;
  logic [2:0] err8;
  logic       held, lof;
  logic [2:0] conf;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int  m_conf;
  bit  m_held, m_lof, m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsync_hold_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .acq_found_i(acq), .err8_i(err8),
    .word28_i(w28), .eos_i(eos), .sync_held_o(held), .lof_o(lof), .conf_o(conf)
  );

  function automatic int f_conf(int c, bit h, bit a, bit w, logic [2:0] f);
    if (a) return 5;
    if (!(w && h)) return c;
    if (&f) return c - 1;
    if (c >= 1 && c < 5) return c + 1;
    return c;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit a, bit w, logic [2:0] f, bit e);
    int  nc;
    bit  nh, hit, nl, np;
    acq = a; w28 = w; err8 = f; eos = e;
    @(posedge clk);
    nc  = f_conf(m_conf, m_held, a, w, f);
    hit = !a && w && m_held && (&f) && m_conf == 1;
    nh  = a ? 1'b1 : (hit ? 1'b0 : m_held);
    nl  = m_lof; np = m_pend;
    if (a) begin nl = 0; np = 0; end
    else begin
      if (m_pend && e) begin nl = 1; np = 0; end
      if (hit) np = 1;
    end
    m_conf = nc; m_held = nh; m_lof = nl; m_pend = np;
    @(negedge clk);
    chk("R4/R5", "conf", int'(conf), m_conf);
    chk("R6", "held", int'(held), int'(m_held));
    chk("R7", "lof", int'(lof), int'(m_lof));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    acq = 0; w28 = 0; eos = 0; err8 = 0;
    rst_n = 0;
    m_conf = 0; m_held = 0; m_lof = 0; m_pend = 0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R1", "held in reset", int'(held), 0);
    chk("R1", "lof in reset", int'(lof), 0);
    chk("R1", "conf in reset", int'(conf), 0);
    rst_n = 1;
    cyc(0, 0, 3'b000, 0);
    chk("R1", "conf after release", int'(conf), 0);

    // R8: strobes before acquisition do nothing
    cyc(0, 1, 3'b111, 0);
    cyc(0, 1, 3'b010, 1);
    chk("R8", "conf while dropped", int'(conf), 0);

    // R2
    cyc(1, 0, 3'b000, 0);
    chk("R2", "conf after acq", int'(conf), 5);
    chk("R2", "held after acq", int'(held), 1);

    // R4 saturation, R3 no strobe
    cyc(0, 1, 3'b011, 0);
    chk("R4", "saturate at 5", int'(conf), 5);
    cyc(0, 0, 3'b111, 0);
    chk("R3", "no change w/o strobe", int'(conf), 5);

    // R6: five downs, eos on the zero edge must not set lof (R7)
    for (int i = 0; i < 4; i++) cyc(0, 1, 3'b111, 0);
    chk("R5", "conf after 4 downs", int'(conf), 1);
    cyc(0, 1, 3'b111, 1);
    chk("R6", "conf zero", int'(conf), 0);
    chk("R6", "held dropped", int'(held), 0);
    chk("R7", "eos on zero edge ignored", int'(lof), 0);
    cyc(0, 0, 3'b000, 0);
    cyc(0, 0, 3'b000, 1);
    chk("R7", "lof on next eos", int'(lof), 1);
    cyc(0, 1, 3'b000, 0);
    chk("R8", "conf stays 0 while dropped", int'(conf), 0);
    chk("R7", "lof sticky", int'(lof), 1);

    // R9: acq clears lof; pending loss cancelled
    cyc(1, 0, 3'b000, 0);
    chk("R9", "lof cleared", int'(lof), 0);
    cyc(0, 1, 3'b111, 0);
    cyc(0, 1, 3'b001, 0);
    chk("R4", "up from 4", int'(conf), 5);
    for (int i = 0; i < 5; i++) cyc(0, 1, 3'b111, 0);
    cyc(1, 0, 3'b000, 0);
    cyc(0, 0, 3'b000, 1);
    chk("R9", "pending cancelled", int'(lof), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit a, w, e;
      logic [2:0] f;
      a = ($urandom % 60) == 0;
      w = ($urandom % 4) == 0;
      e = ($urandom % 5) == 0;
      f = (($urandom % 3) != 0) ? 3'b111 : 3'($urandom);
      cyc(a, w, f, e);
      if (int'(conf) > 5) chk("R10", "conf bound", int'(conf), 5);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule